// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory with Overflow Handling

This block keeps, for a small set of directory entries, the identities of the nodes that hold a cached copy of a memory block in a machine of `NODES` nodes. Each entry stores at most `PTRS` node identifiers of `log2(NODES)` bits each, a count of the identifiers in use and one overflow flag. A coherence controller selects an entry and issues one of four operations: record a new sharer, clear the entry, ask for the invalidation set, or do nothing. The invalidation set comes back at once as a `NODES`-bit mask in which bit n stands for node n.

When a new sharer arrives and every pointer is taken, the entry changes representation according to the `POLICY` parameter. Under the broadcast policy the overflow flag is raised and every node becomes a target. Under the eviction policy the entry never overflows: an existing sharer is pushed out, its identifier is reported so that an invalidation can be sent to it, and the freed pointer is reused. Under the coarse-vector policy the pointer bits are reused as a vector of `NODES/GROUP` bits, bit g standing for nodes g*GROUP to g*GROUP+GROUP-1; this needs `NODES/GROUP <= PTRS*log2(NODES)`.

The control is a two-state machine. In state IDLE the block raises `req_ready`; the transition *accept* (IDLE to EXEC) takes place on a clock edge where `req_valid` is high, latching operation, entry and node. In state EXEC the selected entry is read, updated and written back, and the transition *finish* (EXEC to IDLE) follows unconditionally on the next edge, at which the result outputs are registered.

Top module: `dir_limited_ptr`

## Requirements
- R1: After reset every entry holds no sharer with the overflow flag off, the eviction index is 0, and an invalidation query on any entry returns an all-zero mask.
- R2: An add operation (`req_op`=1) on an entry with a free pointer records the node; a later query (`req_op`=3) returns a mask with exactly the recorded nodes' bits set.
- R3: Adding a node already recorded in a non-overflowed entry leaves the entry unchanged and produces no victim.
- R4: Under the broadcast and coarse-vector policies, adding a new node to an entry whose `PTRS` pointers are all used sets the overflow flag and produces no victim.
- R5: Under the broadcast policy a query on an overflowed entry returns an all-ones mask.
- R6: Under the eviction policy, adding a new node to a full entry pulses `victim_valid` with `victim_id` equal to the pointer in slot k, where k is a rotating index shared by all entries that starts at 0 and advances by one modulo `PTRS` per eviction; the new node takes slot k and the sharer count never exceeds `PTRS`.
- R7: Under the coarse-vector policy, the conversion sets group bit g for each recorded pointer and for the new node lying in nodes g*GROUP..g*GROUP+GROUP-1, and sets no other bit.
- R8: Under the coarse-vector policy a query on an overflowed entry returns a mask with every node of each set group.
- R9: Under the coarse-vector policy an add on an already overflowed entry sets the group bit of the new node.
- R10: A clear operation (`req_op`=2) leaves the entry with zero sharers and the overflow flag off.
- R11: An operation changes only the entry named by `req_idx`; the other entries keep their contents.
- R12: An operation is accepted on an edge with `req_valid` high and `req_ready` high; `req_ready` is low the following cycle; the result (`inv_valid` for a query, `victim_valid` for an eviction) is a one-cycle pulse visible after the second edge; the two pulses never occur together and an operation code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation present |
| req_ready | output | 1 | High in IDLE, operation can be taken |
| req_op | input | 2 | 0 none, 1 add sharer, 2 clear, 3 query invalidation set |
| req_idx | input | log2(ENTRIES) | Entry selected |
| req_node | input | log2(NODES) | Node identifier for an add |
| inv_valid | output | 1 | One-cycle pulse, `inv_mask` valid |
| inv_mask | output | NODES | Nodes to invalidate, bit n = node n |
| victim_valid | output | 1 | One-cycle pulse, an existing sharer was evicted |
| victim_id | output | log2(NODES) | Identifier of the evicted sharer |

## Verification
Three copies of the block, one per overflow policy, receive the same operation stream so that each pattern separates the policies: filling an entry up to its pointer limit shows that all three agree while exact tracking holds, and the next new sharer exposes the broadcast mask, the rotated victim and the group vector. Repeated adds of one node separate duplicate detection from slot allocation, pointers that fall into a single group show that the coarse conversion merges rather than counts, and operations spread over several entries followed by queries of every entry show that the entries are kept apart. A reset in mid-run and a clear-then-refill show that the entry and the eviction index start from a known point again.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_ADD   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_INVAL = 2'd3
    } dir_op_e;

    typedef enum logic [1:0] {
        OVF_BCAST  = 2'd0,
        OVF_EVICT  = 2'd1,
        OVF_COARSE = 2'd2
    } ovf_policy_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EXEC = 1'b1
    } dir_state_e;

endpackage

// File: rtl/dir_ptr_match.sv
module dir_ptr_match #(
    parameter int NODES = 16,
    parameter int PTRS  = 2,
    localparam int ID_W  = $clog2(NODES),
    localparam int CNT_W = $clog2(PTRS + 1),
    localparam int FW    = PTRS * ID_W
) (
    input  logic [FW-1:0]    field,
    input  logic [CNT_W-1:0] cnt,
    input  logic [ID_W-1:0]  node,
    output logic             hit
);
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < PTRS; k++) begin
            if ((k < int'(cnt)) && (field[k*ID_W +: ID_W] == node)) begin
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_coarsen.sv
module dir_coarsen #(
    parameter int NODES = 16,
    parameter int PTRS  = 2,
    parameter int GROUP = 4,
    localparam int ID_W   = $clog2(NODES),
    localparam int FW     = PTRS * ID_W,
    localparam int GROUPS = NODES / GROUP
) (
    input  logic [FW-1:0]     field,
    input  logic [ID_W-1:0]   node,
    output logic [GROUPS-1:0] conv_vec,
    output logic [GROUPS-1:0] node_grp
);
    always_comb begin
        conv_vec = '0;
        node_grp = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if ((int'(node) >= g * GROUP) && (int'(node) < (g + 1) * GROUP)) begin
                node_grp[g] = 1'b1;
            end
            for (int k = 0; k < PTRS; k++) begin
                if ((int'(field[k*ID_W +: ID_W]) >= g * GROUP) &&
                    (int'(field[k*ID_W +: ID_W]) < (g + 1) * GROUP)) begin
                    conv_vec[g] = 1'b1;
                end
            end
        end
        conv_vec = conv_vec | node_grp;
    end
endmodule

// File: rtl/dir_mask_gen.sv
module dir_mask_gen
    import dir_pkg::*;
#(
    parameter int          NODES  = 16,
    parameter int          PTRS   = 2,
    parameter int          GROUP  = 4,
    parameter ovf_policy_e POLICY = OVF_COARSE,
    localparam int ID_W  = $clog2(NODES),
    localparam int CNT_W = $clog2(PTRS + 1),
    localparam int FW    = PTRS * ID_W
) (
    input  logic [FW-1:0]    field,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovf,
    output logic [NODES-1:0] mask
);
    logic [NODES-1:0] precise;

    always_comb begin
        precise = '0;
        for (int k = 0; k < PTRS; k++) begin
            for (int n = 0; n < NODES; n++) begin
                if ((k < int'(cnt)) && (field[k*ID_W +: ID_W] == ID_W'(n))) begin
                    precise[n] = 1'b1;
                end
            end
        end
    end

    if (POLICY == OVF_BCAST) begin : g_bcast
        assign mask = ovf ? '1 : precise;
    end else if (POLICY == OVF_COARSE) begin : g_coarse
        logic [NODES-1:0] expand;
        always_comb begin
            for (int n = 0; n < NODES; n++) begin
                expand[n] = field[n / GROUP];
            end
        end
        assign mask = ovf ? expand : precise;
    end else begin : g_evict
        logic unused_ovf;
        assign unused_ovf = ovf;
        assign mask = precise;
    end
endmodule

// File: rtl/dir_limited_ptr.sv
module dir_limited_ptr
    import dir_pkg::*;
#(
    parameter int          NODES   = 16,
    parameter int          PTRS    = 2,
    parameter int          GROUP   = 4,
    parameter int          ENTRIES = 4,
    parameter ovf_policy_e POLICY  = OVF_COARSE,
    localparam int ID_W   = $clog2(NODES),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(PTRS + 1),
    localparam int RW     = (PTRS > 1) ? $clog2(PTRS) : 1,
    localparam int FW     = PTRS * ID_W,
    localparam int GROUPS = NODES / GROUP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [ID_W-1:0]  req_node,
    output logic             inv_valid,
    output logic [NODES-1:0] inv_mask,
    output logic             victim_valid,
    output logic [ID_W-1:0]  victim_id
);
    dir_state_e state_q, state_d;
    dir_op_e    lat_op;
    logic [IDX_W-1:0] lat_idx;
    logic [ID_W-1:0]  lat_node;

    logic [FW-1:0]    field_q [ENTRIES];
    logic [CNT_W-1:0] cnt_q   [ENTRIES];
    logic             ovf_q   [ENTRIES];
    logic [RW-1:0]    rot_q;

    logic [FW-1:0]     sel_field, new_field;
    logic [CNT_W-1:0]  sel_cnt, new_cnt;
    logic              sel_ovf, new_ovf;
    logic              hit, do_evict, wr_en;
    logic [ID_W-1:0]   evict_id;
    logic [GROUPS-1:0] conv_vec, node_grp;
    logic [NODES-1:0]  mask;

    assign sel_field = field_q[lat_idx];
    assign sel_cnt   = cnt_q[lat_idx];
    assign sel_ovf   = ovf_q[lat_idx];
    assign req_ready = (state_q == S_IDLE);

    dir_ptr_match #(.NODES(NODES), .PTRS(PTRS)) u_match (
        .field(sel_field), .cnt(sel_cnt), .node(lat_node), .hit(hit)
    );

    dir_coarsen #(.NODES(NODES), .PTRS(PTRS), .GROUP(GROUP)) u_coarsen (
        .field(sel_field), .node(lat_node), .conv_vec(conv_vec), .node_grp(node_grp)
    );

    dir_mask_gen #(.NODES(NODES), .PTRS(PTRS), .GROUP(GROUP), .POLICY(POLICY)) u_mask (
        .field(sel_field), .cnt(sel_cnt), .ovf(sel_ovf), .mask(mask)
    );

    // next-state logic: accept in IDLE, finish after one EXEC cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_EXEC;
            S_EXEC: state_d = S_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            lat_op   <= OP_NOP;
            lat_idx  <= '0;
            lat_node <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                lat_op   <= dir_op_e'(req_op);
                lat_idx  <= req_idx;
                lat_node <= req_node;
            end
        end
    end

    // entry update computed during EXEC
    always_comb begin
        new_field = sel_field;
        new_cnt   = sel_cnt;
        new_ovf   = sel_ovf;
        do_evict  = 1'b0;
        evict_id  = '0;
        wr_en     = 1'b0;
        for (int k = 0; k < PTRS; k++) begin
            if (k == int'(rot_q)) evict_id = sel_field[k*ID_W +: ID_W];
        end
        if (state_q == S_EXEC) begin
            unique case (lat_op)
                OP_ADD: begin
                    wr_en = 1'b1;
                    if (sel_ovf) begin
                        if (POLICY == OVF_COARSE) begin
                            new_field[GROUPS-1:0] = sel_field[GROUPS-1:0] | node_grp;
                        end
                    end else if (hit) begin
                        wr_en = 1'b0;
                    end else if (sel_cnt < CNT_W'(PTRS)) begin
                        for (int k = 0; k < PTRS; k++) begin
                            if (k == int'(sel_cnt)) new_field[k*ID_W +: ID_W] = lat_node;
                        end
                        new_cnt = sel_cnt + 1'b1;
                    end else begin
                        unique case (POLICY)
                            OVF_BCAST: new_ovf = 1'b1;
                            OVF_COARSE: begin
                                new_ovf   = 1'b1;
                                new_field = '0;
                                new_field[GROUPS-1:0] = conv_vec;
                            end
                            default: begin
                                do_evict = 1'b1;
                                for (int k = 0; k < PTRS; k++) begin
                                    if (k == int'(rot_q)) new_field[k*ID_W +: ID_W] = lat_node;
                                end
                            end
                        endcase
                    end
                end
                OP_CLEAR: begin
                    wr_en     = 1'b1;
                    new_field = '0;
                    new_cnt   = '0;
                    new_ovf   = 1'b0;
                end
                default: wr_en = 1'b0;
            endcase
        end
    end

    // entry storage and rotating eviction index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                field_q[e] <= '0;
                cnt_q[e]   <= '0;
                ovf_q[e]   <= 1'b0;
            end
            rot_q <= '0;
        end else begin
            if (wr_en) begin
                field_q[lat_idx] <= new_field;
                cnt_q[lat_idx]   <= new_cnt;
                ovf_q[lat_idx]   <= new_ovf;
            end
            if (do_evict) begin
                rot_q <= (rot_q == RW'(PTRS - 1)) ? '0 : rot_q + 1'b1;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_valid    <= 1'b0;
            inv_mask     <= '0;
            victim_valid <= 1'b0;
            victim_id    <= '0;
        end else begin
            inv_valid    <= (state_q == S_EXEC) && (lat_op == OP_INVAL);
            victim_valid <= do_evict;
            if ((state_q == S_EXEC) && (lat_op == OP_INVAL)) inv_mask <= mask;
            if (do_evict) victim_id <= evict_id;
        end
    end

    // R12
    exec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC) |=> (state_q == S_IDLE));

    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R12
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_valid && victim_valid));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry_chk
        // R4
        ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_q[e] |-> (cnt_q[e] == CNT_W'(PTRS)));

        // R4
        ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_q[e]) |-> ($past(cnt_q[e]) == CNT_W'(PTRS)));

        // R6
        evict_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (POLICY == OVF_EVICT) |-> !ovf_q[e]);

        // R10
        clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == S_EXEC && lat_op == OP_CLEAR && lat_idx == IDX_W'(e))
            |=> (cnt_q[e] == '0 && !ovf_q[e]));
    end
endmodule

// File: tb/dir_limited_ptr_bench.sv
module dir_limited_ptr_bench;
    import dir_pkg::*;

    localparam int NODES = 16;
    localparam int PTRS  = 2;
    localparam int GROUP = 4;
    localparam int ENTRIES = 4;
    localparam int NPOL  = 3;   // 0 broadcast, 1 evict, 2 coarse

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [1:0] req_idx = '0;
    logic [3:0] req_node = '0;

    logic        ready_w  [NPOL];
    logic        invv_w   [NPOL];
    logic [15:0] mask_w   [NPOL];
    logic        vicv_w   [NPOL];
    logic [3:0]  vicid_w  [NPOL];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    for (genvar p = 0; p < NPOL; p++) begin : gen_pol
        dir_limited_ptr #(
            .NODES(NODES), .PTRS(PTRS), .GROUP(GROUP), .ENTRIES(ENTRIES),
            .POLICY(ovf_policy_e'(p))
        ) u_dir_limited_ptr (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid), .req_ready(ready_w[p]),
            .req_op(req_op), .req_idx(req_idx), .req_node(req_node),
            .inv_valid(invv_w[p]), .inv_mask(mask_w[p]),
            .victim_valid(vicv_w[p]), .victim_id(vicid_w[p])
        );
    end

    // reference model, written from the requirements
    int m_cnt [NPOL][ENTRIES];
    bit m_ovf [NPOL][ENTRIES];
    int m_ptr [NPOL][ENTRIES][PTRS];
    bit [3:0] m_cv [NPOL][ENTRIES];
    int m_rot [NPOL];

    task automatic model_reset();
        for (int p = 0; p < NPOL; p++) begin
            m_rot[p] = 0;
            for (int e = 0; e < ENTRIES; e++) begin
                m_cnt[p][e] = 0; m_ovf[p][e] = 0; m_cv[p][e] = '0;
                for (int k = 0; k < PTRS; k++) m_ptr[p][e][k] = 0;
            end
        end
    endtask

    function automatic logic [15:0] exp_mask(int p, int e);
        logic [15:0] m = '0;
        if (m_ovf[p][e] && p == 0) return 16'hFFFF;
        if (m_ovf[p][e] && p == 2) begin
            for (int n = 0; n < NODES; n++) m[n] = m_cv[p][e][n / GROUP];
            return m;
        end
        for (int k = 0; k < m_cnt[p][e]; k++) m[m_ptr[p][e][k]] = 1'b1;
        return m;
    endfunction

    task automatic model_op(int p, int op, int e, int n, output bit ev, output int vid);
        bit dup = 0;
        ev = 0; vid = 0;
        if (op == 2) begin
            m_cnt[p][e] = 0; m_ovf[p][e] = 0; m_cv[p][e] = '0;
        end else if (op == 1) begin
            for (int k = 0; k < m_cnt[p][e]; k++) if (m_ptr[p][e][k] == n) dup = 1;
            if (m_ovf[p][e]) begin
                if (p == 2) m_cv[p][e][n / GROUP] = 1'b1;
            end else if (dup) begin
            end else if (m_cnt[p][e] < PTRS) begin
                m_ptr[p][e][m_cnt[p][e]] = n;
                m_cnt[p][e]++;
            end else if (p == 1) begin
                ev = 1; vid = m_ptr[p][e][m_rot[p]];
                m_ptr[p][e][m_rot[p]] = n;
                m_rot[p] = (m_rot[p] + 1) % PTRS;
            end else begin
                m_ovf[p][e] = 1'b1;
                if (p == 2) begin
                    m_cv[p][e] = '0;
                    for (int k = 0; k < PTRS; k++) m_cv[p][e][m_ptr[p][e][k] / GROUP] = 1'b1;
                    m_cv[p][e][n / GROUP] = 1'b1;
                end
            end
        end
    endtask

    task automatic do_op(int op, int e, int n, int rq);
        bit ev [NPOL];
        int vid [NPOL];
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_idx = 2'(e); req_node = 4'(n);
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
        checks++;   // R12: busy during execution
        if (ready_w[0] || ready_w[1] || ready_w[2]) begin
            fails++;
            $display("FAIL R12 ready during exec: actual %b%b%b expected 000",
                     ready_w[0], ready_w[1], ready_w[2]);
        end
        for (int p = 0; p < NPOL; p++) model_op(p, op, e, n, ev[p], vid[p]);
        @(negedge clk);
        for (int p = 0; p < NPOL; p++) begin
            logic [15:0] em = exp_mask(p, e);
            bit eiv = (op == 3);
            checks++;
            if (invv_w[p] !== eiv || vicv_w[p] !== ev[p] ||
                (eiv && mask_w[p] !== em) || (ev[p] && vicid_w[p] !== 4'(vid[p]))) begin
                fails++;
                $display("FAIL R%0d pol %0d op %0d e %0d: actual iv=%b mask=%h vv=%b vid=%0d expected iv=%b mask=%h vv=%b vid=%0d",
                         rq, p, op, e, invv_w[p], mask_w[p], vicv_w[p], vicid_w[p],
                         eiv, em, ev[p], vid[p]);
            end
        end
    endtask

    // stimulus table: {op, entry, node, requirement}
    typedef struct packed { logic [1:0] op; logic [1:0] e; logic [3:0] n; logic [3:0] rq; } vec_t;
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 2'd0, 4'd0,  4'd1},   // R1 empty query
        '{2'd1, 2'd0, 4'd5,  4'd2},   // R2
        '{2'd1, 2'd0, 4'd5,  4'd3},   // R3 duplicate
        '{2'd1, 2'd0, 4'd9,  4'd2},   // R2 entry now full
        '{2'd1, 2'd0, 4'd14, 4'd4},   // R4 R5 R6 R7 overflow / evict 5
        '{2'd1, 2'd0, 4'd2,  4'd9},   // R9 R6 evict 9
        '{2'd1, 2'd0, 4'd14, 4'd3},   // R3 duplicate after eviction
        '{2'd2, 2'd0, 4'd0,  4'd10},  // R10 clear
        '{2'd1, 2'd1, 4'd0,  4'd2},
        '{2'd1, 2'd1, 4'd1,  4'd2},
        '{2'd1, 2'd1, 4'd3,  4'd7},   // R7 one group only, evict 0
        '{2'd0, 2'd1, 4'd7,  4'd12},  // R12 no-op
        '{2'd1, 2'd2, 4'd15, 4'd2},
        '{2'd1, 2'd2, 4'd15, 4'd3},   // R3
        '{2'd1, 2'd3, 4'd7,  4'd11},  // R11
        '{2'd1, 2'd0, 4'd4,  4'd10}   // R10 reuse after clear
    };

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of outputs
        @(negedge clk);
        for (int p = 0; p < NPOL; p++) begin
            checks++;
            if (!ready_w[p] || invv_w[p] || vicv_w[p]) begin
                fails++;
                $display("FAIL R1 pol %0d reset outputs: actual rdy=%b iv=%b vv=%b expected 1 0 0",
                         p, ready_w[p], invv_w[p], vicv_w[p]);
            end
        end
        for (int i = 0; i < NV; i++) begin
            do_op(int'(VEC[i].op), int'(VEC[i].e), int'(VEC[i].n), int'(VEC[i].rq));
            if (VEC[i].op != 2'd3) do_op(3, int'(VEC[i].e), 0, int'(VEC[i].rq));
        end
        // R11: every entry still holds its own contents
        for (int e = 0; e < ENTRIES; e++) do_op(3, e, 0, 11);
        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < ENTRIES; e++) do_op(3, e, 0, 1);
        // R6: eviction index restarts at slot 0 after reset
        do_op(1, 2, 10, 6);
        do_op(1, 2, 11, 6);
        do_op(1, 2, 12, 6);
        do_op(1, 2, 13, 6);
        do_op(3, 2, 0, 8);   // R8 coarse mask of groups 2 and 3
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule